// File: doc/BRIEF.md
# Funnel Shift Unit

The funnel shift unit joins two 32-bit data words into one 64-bit value and shifts that value by a variable count. It then returns a single 32-bit word. The high operand forms bits 63..32 of the joined value and the low operand forms bits 31..0. A direction select picks the word that is returned:

- After a left shift, the unit returns the upper word.
- After a right shift, the unit returns the lower word.

This lets a 32-bit datapath perform one step of a double-width shift in a single operation. It takes three operand inputs, where an ordinary ALU operation takes two.

The count input is 6 bits wide. Counts above 32 are treated as 32. Counts 0 and 32 are exact ends of the range; they are not wrap-around cases. A build parameter places a register on the result. In that build, each accepted input produces its result one clock later, and `outValid` is high in that same cycle.

Top module: `funnel_shift_unit`

## Requirements
- R1: With `dirLeft` = 1, `result` equals bits 63..32 of `{hiWord, loWord} << C`, where C is the effective count.
- R2: With `dirLeft` = 0, `result` equals bits 31..0 of `{hiWord, loWord} >> C`.
- R3: For right mode with C from 1 to 31, `result` equals `(hiWord << (32-C)) | (loWord >> C)` truncated to 32 bits.
- R4: A count of 0 returns `hiWord` in left mode and `loWord` in right mode.
- R5: A count of 32 returns `loWord` in left mode and `hiWord` in right mode.
- R6: Any `shiftAmt` from 33 to 63 gives the same result as a count of 32.
- R7: In the registered build, a result accepted with `inValid` = 1 appears on `result` after the next rising clock edge. `outValid` equals `inValid` delayed by one cycle.
- R8: In the registered build, while `inValid` is 0, `result` keeps its last value whatever the operand inputs do.
- R9: While `rst_n` is low, `result` and `outValid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and mode are valid this cycle |
| dirLeft | input | 1 | 1 = left shift, upper word out; 0 = right shift, lower word out |
| hiWord | input | 32 | High word of the joined value |
| loWord | input | 32 | Low word of the joined value |
| shiftAmt | input | 6 | Shift count; values above 32 act as 32 |
| result | output | 32 | Selected 32-bit word |
| outValid | output | 1 | `result` holds a fresh value |

## Verification
A stuck barrel stage or a wrong clamp appears on `result` one cycle after the first operation whose count has that stage's bit set. For this reason the bench sweeps every count from 0 to 32 in both directions, and then every clamped count. A fault in the bit-reversal around the shared barrel corrupts every right-mode result, with the low and high bits exchanged. A bad capture enable shows as `result` moving while `inValid` is low, within one cycle of the operand change.

// File: rtl/funnel_shift_pkg.sv
package funnel_shift_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // load result register this cycle
    logic pickLeft;  // route operands straight (1) or reversed (0)
  } fsStrobes_t;
endpackage

// File: rtl/funnel_shift_ctrl.sv
module funnel_shift_ctrl
  import funnel_shift_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       dirLeft,
  output fsStrobes_t strobes,
  output logic       outValid
);
  always_comb begin
    strobes.capture  = inValid;
    strobes.pickLeft = dirLeft;
  end

  generate
    if (REGISTERED) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rst_n) validQ <= 1'b0;
        else        validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk = clk & rst_n;
      assign outValid  = inValid;
    end
  endgenerate
endmodule

// File: rtl/funnel_shift_dp.sv
module funnel_shift_dp
  import funnel_shift_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SHIFT_W    = 6,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fsStrobes_t        strobes,
  input  logic [DATA_W-1:0] hiWord,
  input  logic [DATA_W-1:0] loWord,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [DATA_W-1:0] result
);
  localparam int WIDE_W = 2 * DATA_W;
  localparam int STAGES = $clog2(DATA_W) + 1;  // counts 0..DATA_W

  function automatic logic [WIDE_W-1:0] revWide(input logic [WIDE_W-1:0] v);
    for (int i = 0; i < WIDE_W; i++) revWide[i] = v[WIDE_W-1-i];
  endfunction

  function automatic logic [DATA_W-1:0] revWord(input logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W; i++) revWord[i] = v[DATA_W-1-i];
  endfunction

  // Clamp count to DATA_W
  logic [STAGES-1:0] amtC;
  always_comb begin
    if (shiftAmt > SHIFT_W'(DATA_W)) amtC = STAGES'(DATA_W);
    else                             amtC = shiftAmt[STAGES-1:0];
  end

  // One left barrel serves both directions: right = reverse, shift left, reverse
  logic [WIDE_W-1:0] joined;
  logic [WIDE_W-1:0] stg [STAGES];
  assign joined = {hiWord, loWord};
  assign stg[0] = strobes.pickLeft ? joined : revWide(joined);

  genvar k;
  generate
    for (k = 0; k < STAGES - 1; k++) begin : g_stage
      localparam int DIST = 1 << k;
      assign stg[k+1] = amtC[k] ? (stg[k] << DIST) : stg[k];
    end
  endgenerate

  // Final stage only forms the upper word
  localparam int LAST_DIST = 1 << (STAGES - 1);
  logic [DATA_W-1:0] topWord;
  logic [DATA_W-1:0] nextWord;
  assign topWord  = amtC[STAGES-1] ? stg[STAGES-1][WIDE_W-1-LAST_DIST -: DATA_W]
                                   : stg[STAGES-1][WIDE_W-1 -: DATA_W];
  assign nextWord = strobes.pickLeft ? topWord : revWord(topWord);

  generate
    if (REGISTERED) begin : g_reg
      logic [DATA_W-1:0] resQ;
      always_ff @(posedge clk) begin
        if (!rst_n)               resQ <= '0;
        else if (strobes.capture) resQ <= nextWord;
      end
      assign result = resQ;
    end else begin : g_comb
      logic unusedIn;
      assign unusedIn = clk & rst_n & strobes.capture;
      assign result   = nextWord;
    end
  endgenerate
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
  import funnel_shift_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SHIFT_W    = 6,
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic               dirLeft,
  input  logic [DATA_W-1:0]  hiWord,
  input  logic [DATA_W-1:0]  loWord,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [DATA_W-1:0]  result,
  output logic               outValid
);
  fsStrobes_t strobes;

  funnel_shift_ctrl #(.REGISTERED(REGISTERED)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .dirLeft(dirLeft),
    .strobes(strobes), .outValid(outValid)
  );

  funnel_shift_dp #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .REGISTERED(REGISTERED)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .hiWord(hiWord),
    .loWord(loWord), .shiftAmt(shiftAmt), .result(result)
  );
endmodule

// File: rtl/funnel_shift_unit_chk.sv
module funnel_shift_unit_chk #(
  parameter int DATA_W     = 32,
  parameter int SHIFT_W    = 6,
  parameter bit REGISTERED = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               dirLeft,
  input logic [DATA_W-1:0]  hiWord,
  input logic [DATA_W-1:0]  loWord,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic [DATA_W-1:0]  result,
  input logic               outValid
);
  generate
    if (REGISTERED) begin : g_reg
      // R7
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid);
      // R7
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> !outValid);
      // R8
      hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> $stable(result));
      // R4
      zero_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && dirLeft && shiftAmt == '0) |=> result == $past(hiWord));
      // R4
      zero_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && !dirLeft && shiftAmt == '0) |=> result == $past(loWord));
      // R5
      full_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && dirLeft && shiftAmt >= SHIFT_W'(DATA_W)) |=> result == $past(loWord));
      // R6
      full_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && !dirLeft && shiftAmt >= SHIFT_W'(DATA_W)) |=> result == $past(hiWord));
    end
  endgenerate
endmodule

bind funnel_shift_unit funnel_shift_unit_chk #(
  .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .REGISTERED(REGISTERED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .dirLeft(dirLeft),
  .hiWord(hiWord), .loWord(loWord), .shiftAmt(shiftAmt),
  .result(result), .outValid(outValid)
);

// File: tb/funnel_shift_unit_bench.sv
module funnel_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        dirLeft = 1'b0;
  logic [31:0] hiWord = '0;
  logic [31:0] loWord = '0;
  logic [5:0]  shiftAmt = '0;
  logic [31:0] result;
  logic        outValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  funnel_shift_unit u_funnel_shift_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .dirLeft(dirLeft),
    .hiWord(hiWord), .loWord(loWord), .shiftAmt(shiftAmt),
    .result(result), .outValid(outValid)
  );

  function automatic logic [31:0] refShift(input logic [31:0] a, input logic [31:0] b,
                                           input int c, input bit left);
    logic [63:0] v;
    int eff;
    eff = (c > 32) ? 32 : c;
    v = {a, b};
    if (left) refShift = 32'((v << eff) >> 32);
    else      refShift = 32'(v >> eff);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, sample after the capturing edge
  task automatic apply(input bit left, input logic [31:0] a, input logic [31:0] b,
                       input int c);
    @(negedge clk);
    inValid = 1'b1; dirLeft = left; hiWord = a; loWord = b; shiftAmt = 6'(c);
    @(negedge clk);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R9 result", result, 32'h0);
    check("R9 outValid", {31'b0, outValid}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic test_zero();
    apply(1'b1, 32'hDEADBEEF, 32'h01234567, 0);
    check("R4 left", result, 32'hDEADBEEF);
    apply(1'b0, 32'hDEADBEEF, 32'h01234567, 0);
    check("R4 right", result, 32'h01234567);
  endtask

  task automatic test_full();
    apply(1'b1, 32'hA5A5F00F, 32'h3C3C1234, 32);
    check("R5 left", result, 32'h3C3C1234);
    apply(1'b0, 32'hA5A5F00F, 32'h3C3C1234, 32);
    check("R5 right", result, 32'hA5A5F00F);
  endtask

  task automatic test_clamp();
    for (int c = 33; c < 64; c++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      apply(1'b1, a, b, c);
      check("R6 left clamp", result, b);
      apply(1'b0, a, b, c);
      check("R6 right clamp", result, a);
    end
  endtask

  task automatic test_sweep();
    for (int rep = 0; rep < 4; rep++) begin
      for (int c = 0; c <= 32; c++) begin
        logic [31:0] a = $urandom;
        logic [31:0] b = $urandom;
        apply(1'b1, a, b, c);
        check("R1 left", result, refShift(a, b, c, 1'b1));
        apply(1'b0, a, b, c);
        check("R2 right", result, refShift(a, b, c, 1'b0));
      end
    end
  endtask

  task automatic test_formula();
    for (int c = 1; c < 32; c++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      apply(1'b0, a, b, c);
      check("R3 formula", result, (a << (32 - c)) | (b >> c));
    end
  endtask

  task automatic test_valid_hold();
    logic [31:0] kept;
    apply(1'b1, 32'h12345678, 32'h9ABCDEF0, 8);
    check("R7 outValid high", {31'b0, outValid}, 32'h1);
    check("R7 result", result, 32'h3456789A);
    kept = result;
    @(negedge clk);
    inValid = 1'b0; dirLeft = 1'b0; hiWord = 32'hFFFFFFFF; loWord = 32'h0; shiftAmt = 6'd3;
    @(negedge clk);
    check("R7 outValid low", {31'b0, outValid}, 32'h0);
    check("R8 hold", result, kept);
    @(negedge clk);
    dirLeft = 1'b1; shiftAmt = 6'd17;
    @(negedge clk);
    check("R8 hold again", result, kept);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_zero();
    test_full();
    test_clamp();
    test_sweep();
    test_formula();
    test_valid_hold();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule